// File: doc/BRIEF.md
# Cell-Counted Transmit Release and Receive Flow-Control Controller

This block sits beside the transmit and receive packet queues of an Ethernet MAC, where the queue level is counted in 64-byte cells rather than bytes. It stores no data. It follows the cell level of each queue from per-cell push and pop events and makes two decisions from those levels.

On the transmit side, a queued packet is released to the line by raising `tx_start`. This happens as soon as a programmable number of cells has been buffered, which is cut-through operation. A packet shorter than that number is released once its end-of-packet cell has been accepted, which is store-and-forward operation. The release stays up until the transmitter pops the packet's final cell, and then the next packet is judged afresh.

On the receive side, `rx_fc` asks for flow control whenever it is enabled and the receive queue holds at least a programmable number of cells.

Cells enter each queue over a valid/ready handshake. A cell is accepted on a rising clock edge where both valid and ready are high. Ready is low only while the queue is full. The writer may hold valid high while ready is low, and that cell is not taken until ready returns. Pops are plain one-cycle strobes from the consumer. The register write port uses three selects:
- select 0 holds the transmit threshold;
- select 1 holds the receive threshold;
- select 2 holds the flow-control enable in data bit 0.

Top module: `cellq_thresh_ctrl`

## Requirements
- R1: After reset, `tx_start` and `rx_fc` are low, both ready outputs are high, the transmit threshold is 24 cells, the receive threshold is 2 cells, and flow control is disabled.
- R2: A write with `cfg_addr` = 0 loads the transmit threshold from `cfg_wdata[4:0]`. A value below 2 is stored as 2, and a value above 24 is stored as 24.
- R3: With `tx_start` low, `tx_start` rises one cycle after the edge on which the transmit cell count first reaches the threshold.
- R4: A packet with fewer cells than the threshold gets `tx_start` one cycle after the edge that accepts its end-of-packet cell (`tx_in_eop` = 1).
- R5: Once high, `tx_start` stays high until the edge of a pop with `tx_pop_eop` = 1, where it falls. It is re-evaluated from the next cycle.
- R6: `tx_pop` has no effect while `tx_start` is low or the transmit queue is empty.
- R7: `tx_in_ready` is low while the transmit queue holds `TX_DEPTH` cells, and a push offered then is discarded.
- R8: A write with `cfg_addr` = 1 loads the receive threshold from `cfg_wdata[6:0]`, with values above 63 stored as 63. `rx_fc` is high exactly while flow control is enabled and the receive count is at least that threshold, and it updates in the same cycle as the count or the setting it depends on.
- R9: A write with `cfg_addr` = 2 sets the enable from `cfg_wdata[0]`. Writing 0 drops `rx_fc` in the cycle right after the write edge, whatever the count.
- R10: An accepted push and a pop in the same cycle leave the cell count unchanged.
- R11: `rx_in_ready` is low while the receive queue holds `RX_DEPTH` cells, and a push offered then is discarded. `rx_pop` on an empty receive queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 transmit threshold, 1 receive threshold, 2 enable |
| cfg_wdata | input | 7 | Write data |
| tx_in_valid | input | 1 | Transmit cell offered |
| tx_in_eop | input | 1 | Offered transmit cell ends its packet |
| tx_in_ready | output | 1 | Transmit queue can take a cell |
| tx_pop | input | 1 | Transmitter removes one cell |
| tx_pop_eop | input | 1 | Removed cell is the packet's last |
| tx_start | output | 1 | Head packet may go out |
| rx_in_valid | input | 1 | Receive cell offered |
| rx_in_ready | output | 1 | Receive queue can take a cell |
| rx_pop | input | 1 | Consumer removes one receive cell |
| rx_fc | output | 1 | Flow-control request |

## Verification
`tx_start` is a register fed by registered counts, so it answers a push or pop two clock edges after the inputs are driven. The release at a final pop is the exception: it falls on that pop's own edge. `rx_fc` and both ready outputs are decoded from registers and follow one edge after a push, pop or write. The bench drives every input on the falling edge and reads the outputs on the next falling edge, which is after exactly one rising edge. For the transmit path, it compares the result with what the state held before that edge. Every threshold write value from 0 to 31 is swept against packet lengths of 1 to 26 cells, and receive thresholds are walked up and down through the occupancy.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  typedef enum logic [1:0] {
    SEL_TX_THR = 2'd0,
    SEL_RX_THR = 2'd1,
    SEL_RX_EN  = 2'd2
  } cfg_sel_e;

  localparam int TX_THR_W   = 5;
  localparam int RX_THR_W   = 7;
  localparam int TX_THR_MIN = 2;
  localparam int TX_THR_MAX = 24;
  localparam int TX_THR_RST = 24;
  localparam int RX_THR_MAX = 63;
  localparam int RX_THR_RST = 2;
endpackage

// File: rtl/cellq_cfg.sv
module cellq_cfg
  import cellq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [RX_THR_W-1:0] wdata,
  output logic [TX_THR_W-1:0] tx_thr,
  output logic [RX_THR_W-1:0] rx_thr,
  output logic                rx_en
);
  logic [TX_THR_W-1:0] tx_raw, tx_legal;
  logic [RX_THR_W-1:0] rx_legal;

  assign tx_raw = wdata[TX_THR_W-1:0];

  // Keep stored thresholds inside their usable range.
  always_comb begin
    if (tx_raw < TX_THR_W'(TX_THR_MIN))      tx_legal = TX_THR_W'(TX_THR_MIN);
    else if (tx_raw > TX_THR_W'(TX_THR_MAX)) tx_legal = TX_THR_W'(TX_THR_MAX);
    else                                     tx_legal = tx_raw;
    if (wdata > RX_THR_W'(RX_THR_MAX))       rx_legal = RX_THR_W'(RX_THR_MAX);
    else                                     rx_legal = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= TX_THR_W'(TX_THR_RST);
      rx_thr <= RX_THR_W'(RX_THR_RST);
      rx_en  <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_TX_THR: tx_thr <= tx_legal;
        SEL_RX_THR: rx_thr <= rx_legal;
        SEL_RX_EN:  rx_en  <= wdata[0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cellq_occ.sv
module cellq_occ #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic          pop_req,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [CW-1:0] count
);
  assign push_ready = (count != CW'(DEPTH));
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop_req & (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({push_fire, pop_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cellq_tx_gate.sv
module cellq_tx_gate
  import cellq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       count,
  input  logic [TX_THR_W-1:0] thr,
  input  logic                push_fire,
  input  logic                push_eop,
  input  logic                pop_fire,
  input  logic                pop_eop,
  output logic                start
);
  logic [CW-1:0] eop_held;
  logic          eop_in, eop_out, ready_to_go;

  assign eop_in      = push_fire & push_eop;
  assign eop_out     = pop_fire & pop_eop & (eop_held != '0);
  assign ready_to_go = (int'(count) >= int'(thr)) || (eop_held != '0);

  // Count of packet ends currently queued; nonzero means the head packet is whole.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_held <= '0;
    end else begin
      case ({eop_in, eop_out})
        2'b10:   eop_held <= eop_held + CW'(1);
        2'b01:   eop_held <= eop_held - CW'(1);
        default: eop_held <= eop_held;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           start <= 1'b0;
    else if (start && pop_fire && pop_eop) start <= 1'b0;
    else if (!start && ready_to_go)        start <= 1'b1;
  end
endmodule

// File: rtl/cellq_thresh_ctrl.sv
module cellq_thresh_ctrl
  import cellq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [RX_THR_W-1:0] cfg_wdata,
  input  logic                tx_in_valid,
  input  logic                tx_in_eop,
  output logic                tx_in_ready,
  input  logic                tx_pop,
  input  logic                tx_pop_eop,
  output logic                tx_start,
  input  logic                rx_in_valid,
  output logic                rx_in_ready,
  input  logic                rx_pop,
  output logic                rx_fc
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic [TX_THR_W-1:0] tx_thr;
  logic [RX_THR_W-1:0] rx_thr;
  logic                rx_en;
  logic [TX_CW-1:0]    tx_count;
  logic [RX_CW-1:0]    rx_count;
  logic                tx_push_fire, tx_pop_fire, rx_push_fire, rx_pop_fire;

  cellq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .rx_en(rx_en)
  );

  // Transmit cells may only leave once the head packet is released.
  cellq_occ #(.DEPTH(TX_DEPTH)) u_tx_occ (
    .clk(clk), .rst_n(rst_n), .push_valid(tx_in_valid), .push_ready(tx_in_ready),
    .pop_req(tx_pop & tx_start), .push_fire(tx_push_fire), .pop_fire(tx_pop_fire),
    .count(tx_count)
  );

  cellq_tx_gate #(.CW(TX_CW)) u_tx_gate (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .thr(tx_thr),
    .push_fire(tx_push_fire), .push_eop(tx_in_eop),
    .pop_fire(tx_pop_fire), .pop_eop(tx_pop_eop), .start(tx_start)
  );

  cellq_occ #(.DEPTH(RX_DEPTH)) u_rx_occ (
    .clk(clk), .rst_n(rst_n), .push_valid(rx_in_valid), .push_ready(rx_in_ready),
    .pop_req(rx_pop), .push_fire(rx_push_fire), .pop_fire(rx_pop_fire),
    .count(rx_count)
  );

  assign rx_fc = rx_en && (int'(rx_count) >= int'(rx_thr));
endmodule

// File: rtl/cellq_thresh_chk.sv
module cellq_thresh_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_pop,
  input logic       tx_pop_eop,
  input logic       tx_in_ready,
  input logic       rx_in_ready,
  input logic       rx_pop,
  input logic       rx_fc,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic       cfg_en_bit
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !(tx_pop && tx_pop_eop)) |=> tx_start); // R5
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_pop && tx_pop_eop) |=> !tx_start); // R5
  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_in_ready && !(tx_pop && tx_start)) |=> !tx_in_ready); // R7
  AST_RX_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2 && !cfg_en_bit) |=> !rx_fc); // R9
  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_in_ready && !rx_pop) |=> !rx_in_ready); // R11
endmodule

bind cellq_thresh_ctrl cellq_thresh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_pop(tx_pop),
  .tx_pop_eop(tx_pop_eop), .tx_in_ready(tx_in_ready), .rx_in_ready(rx_in_ready),
  .rx_pop(rx_pop), .rx_fc(rx_fc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_en_bit(cfg_wdata[0])
);

// File: tb/cellq_thresh_ctrl_bench.sv
`timescale 1ns/1ps
module cellq_thresh_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [6:0] cfg_wdata;
  logic       tx_in_valid, tx_in_eop, tx_in_ready, tx_pop, tx_pop_eop, tx_start;
  logic       rx_in_valid, rx_in_ready, rx_pop, rx_fc;
  int         checks = 0;
  int         errors = 0;

  cellq_thresh_ctrl u_cellq_thresh_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_in_valid(tx_in_valid), .tx_in_eop(tx_in_eop), .tx_in_ready(tx_in_ready),
    .tx_pop(tx_pop), .tx_pop_eop(tx_pop_eop), .tx_start(tx_start),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_pop(rx_pop), .rx_fc(rx_fc)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 7'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tx_push(input logic eop);
    tx_in_valid = 1'b1; tx_in_eop = eop;
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_eop = 1'b0;
  endtask

  task automatic tx_take(input logic eop);
    tx_pop = 1'b1; tx_pop_eop = eop;
    @(negedge clk);
    tx_pop = 1'b0; tx_pop_eop = 1'b0;
  endtask

  task automatic rx_step(input logic push, input logic pop);
    rx_in_valid = push; rx_pop = pop;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_pop = 1'b0;
  endtask

  // One packet of len cells; wr < 0 keeps the current threshold.
  task automatic run_tx(input int wr, input int thr, input int len);
    string tag;
    bit    clamped;
    clamped = (wr >= 0) && (wr < 2 || wr > 24);
    if (wr >= 0) cfg_write(2'd0, wr);
    for (int i = 1; i <= len; i++) begin
      tx_push(i == len);
      tag = clamped ? "R2" : "R3";
      chk(tag, int'(tx_start), int'(i - 1 >= thr));
    end
    @(negedge clk);
    tag = clamped ? "R2" : ((len < thr) ? "R4" : "R3");
    chk(tag, int'(tx_start), 1);
    for (int j = 1; j <= len; j++) begin
      tx_take(j == len);
      chk("R5", int'(tx_start), int'(j < len));
    end
    @(negedge clk);
    chk("R5", int'(tx_start), 0);
  endtask

  task automatic run_rx(input int wr, input int thr, input int top);
    cfg_write(2'd1, wr);
    chk("R8", int'(rx_fc), int'(0 >= thr));
    for (int k = 1; k <= top; k++) begin
      rx_step(1'b1, 1'b0);
      chk("R8", int'(rx_fc), int'(k >= thr));
    end
    for (int k = top - 1; k >= 0; k--) begin
      rx_step(1'b0, 1'b1);
      chk("R8", int'(rx_fc), int'(k >= thr));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_in_valid = 1'b0; tx_in_eop = 1'b0; tx_pop = 1'b0; tx_pop_eop = 1'b0;
    rx_in_valid = 1'b0; rx_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(tx_start), 0);
    chk("R1", int'(rx_fc), 0);
    chk("R1", int'(tx_in_ready), 1);
    chk("R1", int'(rx_in_ready), 1);
    // R1: default transmit threshold 24 and disabled flow control
    run_tx(-1, 24, 25);
    rx_step(1'b1, 1'b0); rx_step(1'b1, 1'b0);
    chk("R1", int'(rx_fc), 0);
    cfg_write(2'd2, 1);
    chk("R1", int'(rx_fc), 1);          // default receive threshold 2
    rx_step(1'b0, 1'b1);
    chk("R1", int'(rx_fc), 0);
    rx_step(1'b0, 1'b1);

    // R2 R3 R4: every write value against packet lengths 1..26
    for (int w = 0; w < 32; w++) begin
      for (int len = 1; len <= 26; len++) begin
        run_tx(w, (w < 2) ? 2 : ((w > 24) ? 24 : w), len);
      end
    end

    // R6: pops ignored before release
    cfg_write(2'd0, 2);
    tx_push(1'b0);
    @(negedge clk);
    chk("R6", int'(tx_start), 0);
    tx_take(1'b1);
    chk("R6", int'(tx_start), 0);
    tx_push(1'b0);
    @(negedge clk);
    chk("R6", int'(tx_start), 1);
    tx_take(1'b0); tx_take(1'b1);
    @(negedge clk);
    chk("R6", int'(tx_start), 0);

    // R7: full transmit queue refuses a cell
    cfg_write(2'd0, 24);
    for (int i = 1; i <= 32; i++) tx_push(i == 32);
    chk("R7", int'(tx_in_ready), 0);
    tx_push(1'b1);
    chk("R7", int'(tx_in_ready), 0);
    for (int j = 1; j <= 32; j++) tx_take(j == 32);
    @(negedge clk); @(negedge clk);
    chk("R7", int'(tx_start), 0);
    chk("R7", int'(tx_in_ready), 1);

    // R8: receive thresholds walked through occupancy
    for (int w = 0; w <= 9; w++) run_rx(w, w, w + 2);

    // R8 R11: clamp to 63 and full receive queue
    cfg_write(2'd1, 100);
    for (int k = 1; k <= 64; k++) begin
      rx_step(1'b1, 1'b0);
      chk("R8", int'(rx_fc), int'(k >= 63));
    end
    chk("R11", int'(rx_in_ready), 0);
    rx_step(1'b1, 1'b0);
    chk("R11", int'(rx_in_ready), 0);
    rx_step(1'b0, 1'b1);
    chk("R11", int'(rx_fc), 1);
    rx_step(1'b0, 1'b1);
    chk("R11", int'(rx_fc), 0);
    for (int k = 0; k < 62; k++) rx_step(1'b0, 1'b1);
    rx_step(1'b0, 1'b1);                 // pop on empty
    cfg_write(2'd1, 2);
    rx_step(1'b1, 1'b0);
    chk("R11", int'(rx_fc), 0);
    rx_step(1'b1, 1'b0);
    chk("R11", int'(rx_fc), 1);
    rx_step(1'b0, 1'b1); rx_step(1'b0, 1'b1);

    // R10: push and pop together keep the level
    cfg_write(2'd1, 3);
    for (int k = 0; k < 3; k++) rx_step(1'b1, 1'b0);
    chk("R10", int'(rx_fc), 1);
    rx_step(1'b1, 1'b1);
    chk("R10", int'(rx_fc), 1);
    rx_step(1'b0, 1'b1);
    chk("R10", int'(rx_fc), 0);
    rx_step(1'b1, 1'b0);

    // R9: disabling drops the request at once
    chk("R9", int'(rx_fc), 1);
    cfg_write(2'd2, 0);
    chk("R9", int'(rx_fc), 0);
    cfg_write(2'd2, 1);
    chk("R9", int'(rx_fc), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule